// File: doc/BRIEF.md
# Instruction Fetch Stage with Return-Address Stack

This block is the front stage of a small in-order pipeline. It holds an 8-bit program counter and reads a 32-bit instruction word from a 256-word instruction store. The store is read combinationally at the current counter value. Each cycle it hands decode the fetched word together with the address it came from. Without other requests, the counter steps by one on every rising clock edge and wraps from 255 to 0.

The execute stage steers the counter in two ways. A jump request with a target address replaces the counter. A 2-bit stack command pushes a return address or pops one. A branch-with-return pairs a push with a jump: the pushed value is the branch's own address plus one. A return pops the newest saved address into the counter.

The stack is eight entries deep and has full and empty flags. Requests it cannot honour are dropped and set a sticky error flag. The instruction store is filled before execution through a simple synchronous write port.

Top module: `fetch_unit`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets the counter to 0, empties the stack (stk_empty=1, stk_full=0) and clears stk_err.
- R2: With no jump and no successful pop, the counter rises by one at each rising edge, wrapping from 255 to 0.
- R3: With jump_en high at a rising edge and no successful pop, the counter takes jump_pc at that edge.
- R4: The store holds 256 words of 32 bits that all read 0 until written. When ld_we is high at a rising edge, ld_data is written to word ld_addr at that edge, and the write is visible from then on.
- R5: dec_pc equals the counter, and dec_instr equals the store word at the counter, in the same cycle with no added register.
- R6: stk_cmd=2'b10 (push) on a stack that is not full saves stk_link_pc+1 (modulo 256) as the newest entry. The push alone does not change the counter's step.
- R7: stk_cmd=2'b01 (pop) on a stack that is not empty removes the newest entry and loads it into the counter at that edge, in last-in first-out order.
- R8: When a successful pop and jump_en occur at the same edge, the popped address wins over jump_pc.
- R9: stk_full is 1 exactly when 8 entries are held. A push while full is dropped: the contents are unchanged, so later pops return the first eight. It also sets stk_err.
- R10: A pop while empty is dropped and sets stk_err. The counter then follows jump_pc or the step as if no pop had been asked. stk_err stays set until reset.
- R11: stk_cmd=2'b00 and the reserved code 2'b11 leave the stack and stk_err unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_we | input | 1 | Instruction store write enable |
| ld_addr | input | 8 | Instruction store write address |
| ld_data | input | 32 | Instruction store write data |
| jump_en | input | 1 | Jump request from execute |
| jump_pc | input | 8 | Jump target address |
| stk_cmd | input | 2 | Stack command: 00 none, 01 pop, 10 push, 11 reserved |
| stk_link_pc | input | 8 | Address of the branch-with-return instruction being pushed |
| dec_instr | output | 32 | Fetched instruction to decode |
| dec_pc | output | 8 | Address of the fetched instruction |
| stk_full | output | 1 | Stack holds 8 entries |
| stk_empty | output | 1 | Stack holds no entry |
| stk_err | output | 1 | Sticky flag for a dropped push or pop |

## Verification
Every result of a request is due one edge after the request is sampled: the new counter, the new stack flags and the error flag. The fetched word follows the counter in the same cycle, so it also shows up one edge after a jump, a pop or a store write. The bench applies inputs at the falling edge. It advances a behavioural model at the rising edge and compares all outputs at the next falling edge. Each comparison therefore sees exactly the state produced by one edge.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  localparam int unsigned PC_W      = 8;
  localparam int unsigned INSTR_W   = 32;
  localparam int unsigned STK_DEPTH = 8;

  typedef enum logic [1:0] {
    STK_NONE = 2'b00,
    STK_POP  = 2'b01,
    STK_PUSH = 2'b10,
    STK_RSVD = 2'b11
  } stk_cmd_e;

  function automatic logic [PC_W-1:0] seq_next(input logic [PC_W-1:0] pc);
    return pc + PC_W'(1);
  endfunction

  function automatic logic [PC_W-1:0] link_value(input logic [PC_W-1:0] branch_pc);
    return branch_pc + PC_W'(1);
  endfunction
endpackage

// File: rtl/instr_store.sv
module instr_store #(
  parameter int unsigned AW = fetch_pkg::PC_W,
  parameter int unsigned DW = fetch_pkg::INSTR_W
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];

  initial begin
    for (int i = 0; i < WORDS; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/return_stack.sv
module return_stack
  import fetch_pkg::*;
#(
  parameter int unsigned AW    = PC_W,
  parameter int unsigned DEPTH = STK_DEPTH
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    cmd,
  input  logic [AW-1:0] push_val,
  output logic [AW-1:0] top_val,
  output logic          pop_take,
  output logic          full,
  output logic          empty,
  output logic          err
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0]    mem [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic [PTR_W-1:0] top_idx;
  logic             push_req, pop_req, push_take, bad_push, bad_pop;

  assign full      = (cnt == CNT_W'(DEPTH));
  assign empty     = (cnt == '0);
  assign push_req  = (cmd == STK_PUSH);
  assign pop_req   = (cmd == STK_POP);
  assign push_take = push_req && !full;
  assign pop_take  = pop_req && !empty;
  assign bad_push  = push_req && full;
  assign bad_pop   = pop_req && empty;
  assign top_idx   = PTR_W'(cnt - CNT_W'(1));
  assign top_val   = empty ? '0 : mem[top_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      err <= 1'b0;
    end else begin
      if (bad_push || bad_pop) err <= 1'b1;
      if (push_take) begin
        mem[PTR_W'(cnt)] <= push_val;
        cnt <= cnt + CNT_W'(1);
      end else if (pop_take) begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  assert_reset_empty_R1: assert property (@(posedge clk) rst |=> (empty && !err));
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst) cnt <= CNT_W'(DEPTH));
  assert_flag_excl_R9: assert property (@(posedge clk) disable iff (rst) !(full && empty));
  assert_push_top_R6: assert property (@(posedge clk) disable iff (rst)
    push_take |=> (top_val == $past(push_val)));
  assert_drop_push_R9: assert property (@(posedge clk) disable iff (rst)
    bad_push |=> (err && full && $stable(top_val)));
  assert_drop_pop_R10: assert property (@(posedge clk) disable iff (rst)
    bad_pop |=> (err && empty));
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst) err |=> err);
  assert_idle_cmd_R11: assert property (@(posedge clk) disable iff (rst)
    (cmd == STK_NONE || cmd == STK_RSVD) |=> ($stable(cnt) && $stable(err)));
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import fetch_pkg::*;
#(
  parameter int unsigned AW = PC_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          jump_en,
  input  logic [AW-1:0] jump_pc,
  input  logic          pop_take,
  input  logic [AW-1:0] pop_pc,
  output logic [AW-1:0] pc
);
  logic [AW-1:0] pc_next;

  always_comb begin
    if (pop_take)     pc_next = pop_pc;
    else if (jump_en) pc_next = jump_pc;
    else              pc_next = AW'(seq_next(PC_W'(pc)));
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

  assert_reset_pc_R1: assert property (@(posedge clk) rst |=> (pc == '0));
  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!jump_en && !pop_take) |=> (pc == $past(pc) + AW'(1)));
  assert_jump_load_R3: assert property (@(posedge clk) disable iff (rst)
    (jump_en && !pop_take) |=> (pc == $past(jump_pc)));
  assert_pop_wins_R8: assert property (@(posedge clk) disable iff (rst)
    pop_take |=> (pc == $past(pop_pc)));
endmodule

// File: rtl/fetch_unit.sv
module fetch_unit
  import fetch_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_we,
  input  logic [PC_W-1:0]    ld_addr,
  input  logic [INSTR_W-1:0] ld_data,
  input  logic               jump_en,
  input  logic [PC_W-1:0]    jump_pc,
  input  logic [1:0]         stk_cmd,
  input  logic [PC_W-1:0]    stk_link_pc,
  output logic [INSTR_W-1:0] dec_instr,
  output logic [PC_W-1:0]    dec_pc,
  output logic               stk_full,
  output logic               stk_empty,
  output logic               stk_err
);
  logic [PC_W-1:0] pc, ret_addr;
  logic            pop_take;

  return_stack #(.AW(PC_W), .DEPTH(STK_DEPTH)) u_stack (
    .clk      (clk),
    .rst      (rst),
    .cmd      (stk_cmd),
    .push_val (link_value(stk_link_pc)),
    .top_val  (ret_addr),
    .pop_take (pop_take),
    .full     (stk_full),
    .empty    (stk_empty),
    .err      (stk_err)
  );

  pc_sequencer #(.AW(PC_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .jump_en  (jump_en),
    .jump_pc  (jump_pc),
    .pop_take (pop_take),
    .pop_pc   (ret_addr),
    .pc       (pc)
  );

  instr_store #(.AW(PC_W), .DW(INSTR_W)) u_store (
    .clk   (clk),
    .we    (ld_we),
    .waddr (ld_addr),
    .wdata (ld_data),
    .raddr (pc),
    .rdata (dec_instr)
  );

  assign dec_pc = pc;

  assert_store_write_R4: assert property (@(posedge clk)
    (ld_we && !rst && !jump_en && !pop_take && (ld_addr == pc + PC_W'(1)))
      |=> (dec_instr == $past(ld_data)));
endmodule

// File: tb/fetch_unit_tb.sv
module fetch_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst = 1;
  logic        ld_we = 0;
  logic [7:0]  ld_addr = 0;
  logic [31:0] ld_data = 0;
  logic        jump_en = 0;
  logic [7:0]  jump_pc = 0;
  logic [1:0]  stk_cmd = 0;
  logic [7:0]  stk_link_pc = 0;
  logic [31:0] dec_instr;
  logic [7:0]  dec_pc;
  logic        stk_full, stk_empty, stk_err;

  fetch_unit u_dut (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .jump_en(jump_en), .jump_pc(jump_pc), .stk_cmd(stk_cmd), .stk_link_pc(stk_link_pc),
    .dec_instr(dec_instr), .dec_pc(dec_pc), .stk_full(stk_full),
    .stk_empty(stk_empty), .stk_err(stk_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  logic [31:0] m_store [256];
  int          m_pc;
  int          m_stk[$];
  bit          m_err;

  int    checks = 0;
  int    failures = 0;
  string req = "R1";
  bit    done = 0;
  int    cycles = 0;

  task automatic check(input string r, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  task automatic compare();
    check(req, "dec_pc", dec_pc, m_pc);
    check(req, "dec_instr", dec_instr, m_store[m_pc]);
    check(req, "stk_empty", stk_empty, m_stk.size() == 0);
    check(req, "stk_full", stk_full, m_stk.size() == 8);
    check(req, "stk_err", stk_err, m_err);
  endtask

  task automatic model_edge();
    bit pop_ok;
    int nxt;
    if (ld_we) m_store[ld_addr] = ld_data;
    if (rst) begin
      m_pc = 0; m_stk.delete(); m_err = 0;
      return;
    end
    pop_ok = (stk_cmd == 2'b01) && m_stk.size() > 0;
    if (stk_cmd == 2'b01 && m_stk.size() == 0) m_err = 1;
    if (stk_cmd == 2'b10 && m_stk.size() == 8) m_err = 1;
    if (pop_ok)       nxt = m_stk.pop_back();
    else if (jump_en) nxt = jump_pc;
    else              nxt = (m_pc + 1) % 256;
    if (stk_cmd == 2'b10 && m_stk.size() < 8) m_stk.push_back((stk_link_pc + 1) % 256);
    m_pc = nxt;
  endtask

  // one cycle: compare at falling edge, drive, then advance model at rising edge
  task automatic cyc(input bit r, input bit we, input int wa, input logic [31:0] wd,
                     input bit je, input int jp, input logic [1:0] cmd, input int lk);
    @(negedge clk);
    compare();
    rst = r; ld_we = we; ld_addr = 8'(wa); ld_data = wd;
    jump_en = je; jump_pc = 8'(jp); stk_cmd = cmd; stk_link_pc = 8'(lk);
    @(posedge clk);
    model_edge();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 2'b00, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) m_store[i] = '0;
    m_pc = 0; m_err = 0;
    @(posedge clk);
    model_edge();
    // R1 reset state; R4 empty store reads zero
    req = "R1"; cyc(1, 0, 0, 0, 0, 0, 2'b00, 0);
    req = "R4";
    for (int i = 0; i < 24; i++) cyc(1, 1, i, 32'hC3000000 ^ (i * 32'h01030507), 0, 0, 2'b00, 0);
    cyc(1, 0, 0, 0, 0, 0, 2'b00, 0);
    // R2 / R5 sequential fetch
    req = "R2_R5"; idle(30);
    // R4 write ahead of the counter while running
    req = "R4"; cyc(0, 1, m_pc + 2, 32'hDEADBEEF, 0, 0, 2'b00, 0); idle(3);
    // R3 jump, then R2 wrap 255 -> 0
    req = "R3"; cyc(0, 0, 0, 0, 1, 250, 2'b00, 0);
    req = "R2"; idle(10);
    req = "R3"; cyc(0, 0, 0, 0, 1, 5, 2'b00, 0); idle(2);
    // R6 branch-with-return: push link+1 and jump together
    req = "R6"; cyc(0, 0, 0, 0, 1, 40, 2'b10, m_pc); idle(2);
    cyc(0, 0, 0, 0, 1, 80, 2'b10, m_pc); idle(2);
    cyc(0, 0, 0, 0, 0, 0, 2'b10, 255); idle(2);
    // R7 pops in LIFO order
    req = "R7"; cyc(0, 0, 0, 0, 0, 0, 2'b01, 0); idle(1);
    cyc(0, 0, 0, 0, 0, 0, 2'b01, 0); idle(1);
    // R8 pop and jump together
    req = "R8"; cyc(0, 0, 0, 0, 1, 200, 2'b01, 0); idle(1);
    // R11 reserved and none codes
    req = "R11"; cyc(0, 0, 0, 0, 0, 0, 2'b11, 9); cyc(0, 0, 0, 0, 0, 0, 2'b00, 9); idle(1);
    // R9 fill to eight, then overflow
    req = "R9";
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0, 0, 0, 2'b10, 10 * i + 3);
    cyc(0, 0, 0, 0, 1, 60, 2'b10, 99); idle(1);
    for (int i = 0; i < 8; i++) begin cyc(0, 0, 0, 0, 0, 0, 2'b01, 0); idle(1); end
    // R10 underflow is dropped, error stays
    req = "R10"; cyc(0, 0, 0, 0, 1, 120, 2'b01, 0); idle(2);
    cyc(0, 0, 0, 0, 0, 0, 2'b01, 0); idle(3);
    cyc(0, 0, 0, 0, 0, 0, 2'b10, 7); cyc(0, 0, 0, 0, 0, 0, 2'b01, 0); idle(2);
    // R1 reset clears error and stack
    req = "R1"; cyc(0, 0, 0, 0, 0, 0, 2'b10, 1); cyc(1, 0, 0, 0, 0, 0, 2'b00, 0); idle(3);
    @(negedge clk); compare();
    finish_run();
  end
endmodule